// File: doc/BRIEF.md
# Four-Sample Sum and Square-Sum Tree

This block takes four unsigned samples, all presented in the same cycle. It returns two results: their plain total and the total of their squares. Each result comes from a two-level adder tree. The first level adds the samples in two pairs. The second level adds the two pair results. The plain tree and the square tree run side by side and have the same shape.

The parameter `PIPE` selects how the trees are timed. With `PIPE = 0`, both adder levels sit in one combinational path, followed by one output register. With `PIPE = 1`, a register holds the pair results between the two levels, so the clock period is set by the slower of the two levels. A new group may arrive every cycle, and there is no back-pressure.

Top module: `quad_sq_sum`

## Requirements
- R1: After reset (rst_ni low), out_valid_o is 0 and sum_o and sq_sum_o are 0.
- R2: sum_o equals the sum of the four 8-bit lanes of samples_i, where lane k is bits [8k+7:8k]. It is 10 bits wide and never overflows: the maximum is 1020.
- R3: sq_sum_o equals the sum of the squares of the four lanes. It is 18 bits wide and never overflows: the maximum is 260100.
- R4: With PIPE = 0, out_valid_o follows in_valid_i one cycle later, and the results for that group appear in the same cycle.
- R5: With PIPE = 1, out_valid_o follows in_valid_i two cycles later, and the results for that group appear in the same cycle.
- R6: A group can be accepted every cycle. Back-to-back groups each produce their own correct result, in the order they arrived.
- R7: While in_valid_i is low, no data register is loaded. The results of the last valid group stay on sum_o and sq_sum_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A sample group is present on samples_i |
| samples_i | input | 32 | Four 8-bit lanes; lane k is bits [8k+7:8k] |
| out_valid_o | output | 1 | Results are valid |
| sum_o | output | 10 | Sum of the four lanes |
| sq_sum_o | output | 18 | Sum of the squares of the four lanes |

## Verification
The assertions assume that samples_i is fully known whenever in_valid_i is high. They also assume that in_valid_i is never X after reset is released, because the valid pipeline copies it directly. The bench drives known values on every cycle, including cycles where in_valid_i is low. On those cycles it applies unrelated data on purpose, to show that idle cycles leave the held results unchanged. Both tree variants are built side by side, so the latency checks cover each variant against the same stimulus.

// File: rtl/quad_sq_sum_pkg.sv
package quad_sq_sum_pkg;
  parameter int unsigned SW    = 8;
  parameter int unsigned LANES = 4;
  localparam int unsigned QW   = 2 * SW;
  localparam int unsigned PSW  = SW + 1;
  localparam int unsigned PQW  = QW + 1;
  localparam int unsigned TSW  = SW + 2;
  localparam int unsigned TQW  = QW + 2;

  typedef struct packed {
    logic [PSW-1:0] s;
    logic [PQW-1:0] q;
  } pair_t;
endpackage

// File: rtl/pair_add.sv
module pair_add
  import quad_sq_sum_pkg::*;
(
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  output pair_t         pair_o
);
  logic [QW-1:0] a_sq, b_sq;
  assign a_sq     = QW'(a_i) * QW'(a_i);
  assign b_sq     = QW'(b_i) * QW'(b_i);
  assign pair_o.s = PSW'(a_i) + PSW'(b_i);
  assign pair_o.q = PQW'(a_sq) + PQW'(b_sq);
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/quad_sq_sum.sv
module quad_sq_sum
  import quad_sq_sum_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [LANES*SW-1:0] samples_i,
  output logic               out_valid_o,
  output logic [TSW-1:0]     sum_o,
  output logic [TQW-1:0]     sq_sum_o
);
  localparam int unsigned NPAIR = LANES / 2;
  localparam int unsigned PW    = $bits(pair_t);

  pair_t pair_c [NPAIR];
  pair_t pair_l [NPAIR];
  logic  mid_valid;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_add u_pair (
      .a_i   (samples_i[(2*p)*SW +: SW]),
      .b_i   (samples_i[(2*p+1)*SW +: SW]),
      .pair_o(pair_c[p])
    );
  end

  if (PIPE) begin : g_pipe
    for (genvar p = 0; p < NPAIR; p++) begin : g_mid
      stage_reg #(.W(PW)) u_mid (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (in_valid_i),
        .d_i   (pair_c[p]),
        .q_o   (pair_l[p])
      );
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mid_valid <= 1'b0;
      else         mid_valid <= in_valid_i;
    end
  end else begin : g_comb
    for (genvar p = 0; p < NPAIR; p++) begin : g_mid
      assign pair_l[p] = pair_c[p];
    end
    assign mid_valid = in_valid_i;
  end

  logic [TSW-1:0] tot_s;
  logic [TQW-1:0] tot_q;
  assign tot_s = TSW'(pair_l[0].s) + TSW'(pair_l[1].s);
  assign tot_q = TQW'(pair_l[0].q) + TQW'(pair_l[1].q);

  stage_reg #(.W(TSW + TQW)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mid_valid),
    .d_i   ({tot_s, tot_q}),
    .q_o   ({sum_o, sq_sum_o})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= mid_valid;
  end

  // R2/R3: the result widths cover the largest possible totals
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= TSW'(LANES * ((1 << SW) - 1)));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_sum_o <= TQW'(LANES * ((1 << SW) - 1) * ((1 << SW) - 1)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mid_valid |=> $stable({sum_o, sq_sum_o}));
  if (PIPE) begin : g_a5
    a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> ##1 out_valid_o);
  end else begin : g_a4
    a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);
  end
  a_r1_valid_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(out_valid_o));
endmodule

// File: tb/test_quad_sq_sum.sv
module test_quad_sq_sum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] samples_i = '0;
  logic        ov0, ov1;
  logic [9:0]  s0, s1;
  logic [17:0] q0, q1;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  quad_sq_sum #(.PIPE(1'b1)) i_quad_sq_sum (
    .clk_i, .rst_ni, .in_valid_i, .samples_i,
    .out_valid_o(ov1), .sum_o(s1), .sq_sum_o(q1));
  quad_sq_sum #(.PIPE(1'b0)) i_quad_sq_sum_comb (
    .clk_i, .rst_ni, .in_valid_i, .samples_i,
    .out_valid_o(ov0), .sum_o(s0), .sq_sum_o(q0));

  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0304,
    32'h80FF_0001, 32'h1234_5678, 32'hFF00_FF00};

  function automatic logic [9:0] esum(logic [31:0] v);
    int t = 0;
    for (int k = 0; k < 4; k++) t += v[8*k +: 8];
    return 10'(t);
  endfunction
  function automatic logic [17:0] esq(logic [31:0] v);
    int t = 0;
    for (int k = 0; k < 4; k++) t += int'(v[8*k +: 8]) * int'(v[8*k +: 8]);
    return 18'(t);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  // drive at negedge, launch at next posedge
  task automatic drive(logic v, logic [31:0] d);
    @(negedge clk_i);
    in_valid_i = v;
    samples_i  = d;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", {31'd0, ov1}, 0);
    chk("R1 sum", {22'd0, s1}, 0);
    chk("R1 sq", {14'd0, q1}, 0);
    chk("R1 comb", {ov0, s0, q0}, 0);
    rst_ni = 1'b1;

    // R2 R3 R6: back-to-back vectors; comb lags 1 cycle, pipe 2
    for (int i = 0; i < NV + 2; i++) begin
      if (i < NV) drive(1'b1, VEC[i]); else drive(1'b0, 32'hA5A5_A5A5);
      if (i >= 1 && i - 1 < NV) begin
        chk("R4 valid", {31'd0, ov0}, 1);
        chk("R2 comb sum", {22'd0, s0}, {22'd0, esum(VEC[i-1])});
        chk("R3 comb sq", {14'd0, q0}, {14'd0, esq(VEC[i-1])});
      end
      if (i >= 2) begin
        chk("R5 valid", {31'd0, ov1}, 1);
        chk("R2 R6 pipe sum", {22'd0, s1}, {22'd0, esum(VEC[i-2])});
        chk("R3 R6 pipe sq", {14'd0, q1}, {14'd0, esq(VEC[i-2])});
      end
    end

    // R7: idle cycles with noise keep last results
    repeat (4) drive(1'b0, 32'h1357_9BDF);
    chk("R7 valid", {30'd0, ov1, ov0}, 0);
    chk("R7 pipe sum", {22'd0, s1}, {22'd0, esum(VEC[NV-1])});
    chk("R7 pipe sq", {14'd0, q1}, {14'd0, esq(VEC[NV-1])});
    chk("R7 comb sum", {22'd0, s0}, {22'd0, esum(VEC[NV-1])});

    // R4/R5 single-shot latency
    drive(1'b1, 32'hFFFF_FFFF);
    drive(1'b0, 32'h0);
    chk("R4 one cycle", {30'd0, ov1, ov0}, 32'd1);
    chk("R3 max sq", {14'd0, q0}, 260100);
    drive(1'b0, 32'h0);
    chk("R5 two cycles", {30'd0, ov1, ov0}, 32'd2);
    chk("R2 max sum", {22'd0, s1}, 1020);

    // R1 reset mid-stream
    drive(1'b1, 32'h0909_0909);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", {ov1, ov0, s1, q1}, 0);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule